// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external host read and write a 64-entry, byte-wide register file over a four-wire serial link. The host drives the serial clock, the data-in line and an active-low select. The block drives the data-out line. SPI mode 0 is used: the clock idles low, data is sampled on the rising edge and changed on the falling edge.

Every transfer opens with a command byte. Its top bit picks the direction (1 = read, 0 = write). Bits 6 down to 1 hold the register address, and bit 0 must be zero. On a write, every later byte goes to that one address, so a host can pour a stream into a single data port. On a read, each later byte the host sends names the next address in bits 6 to 1, while the data-out line returns the contents of the address named one byte earlier.

All three pins pass through multi-stage synchronisers into the system clock, and edges are detected there. The register-file strobes are therefore ordinary single-cycle pulses in the system clock domain. The register file must present read data in the cycle after the read strobe.

Top module: `spi_regport`

## Requirements
- R1: After reset, spi_miso, reg_rd_en and reg_wr_en are all 0.
- R2: Data-in is sampled on rising serial clock edges, MSB first. In the command byte, bit 7 = 0 selects a write and bits 6..1 are the register address put on reg_addr.
- R3: In a write transfer, each complete byte after the command gives exactly one reg_wr_en pulse carrying that byte on reg_wdata and the command's address. spi_miso stays 0 for the whole transfer.
- R4: In a read transfer (command bit 7 = 1), the command byte gives one reg_rd_en at its address. Each later byte gives one reg_rd_en at that byte's bits 6..1. During byte k (k ≥ 1), spi_miso shifts out, MSB first, the data of the address named in byte k-1. During the command byte, spi_miso is 0.
- R5: spi_miso changes only after a falling serial clock edge, or on deselect. It holds steady while the serial clock is high.
- R6: A command byte with bit 0 = 1 is invalid. It causes no strobe for the rest of the transfer, and spi_miso stays 0.
- R7: Raising select abandons any partial byte, produces no strobe for it and drives spi_miso to 0. The next transfer starts again with a command byte.
- R8: reg_rd_en and reg_wr_en are single-cycle pulses and are never high together.
- R9: reg_rdata is captured in the cycle after reg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low transfer select |
| spi_miso | output | 1 | Serial data to the host |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | 6 | Register address for either strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd_en |

## Verification
Directed transfers cover single and multi-byte writes, including a write to the top address 3Fh. Reads of up to four bytes show the one-byte lag between the address sent and the data returned, and show that a streamed write lands only on its single address. An invalid command and a select raised partway through a byte, both in the command byte and in a data byte, show that partial or rejected traffic leaves the register file untouched and that the bit counter realigns. Seeded random transfers of mixed kind, address and length then check that the bench's register model and the returned data stay consistent across back-to-back transfers.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 2;
    localparam int NREGS  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WRITE,
        PH_READ,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic              legal;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.is_read = b[BYTE_W-1];
        c.addr    = b[BYTE_W-2:1];
        c.legal   = ~b[0];
        return c;
    endfunction

endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic mosi,
    input  logic cs_n,
    output logic sel,
    output logic rise,
    output logic fall,
    output logic mosi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b100;

    logic [STAGES-1:0][NPIN-1:0] chain;
    logic                        sck_last;
    logic                        sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_LVL;
            sck_last <= 1'b0;
        end else begin
            chain[0] <= {cs_n, mosi, sck};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_last <= chain[STAGES-1][0];
        end
    end

    assign sck_s  = chain[STAGES-1][0];
    assign mosi_s = chain[STAGES-1][1];
    assign sel    = ~chain[STAGES-1][2];
    assign rise   = sel &  sck_s & ~sck_last;
    assign fall   = sel & ~sck_s &  sck_last;

endmodule

// File: rtl/spi_rp_rx.sv
module spi_rp_rx
    import spi_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rise,
    input  logic              mosi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_q,
    output logic              at_boundary
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            cnt       <= '0;
            sh        <= '0;
            byte_done <= 1'b0;
            byte_q    <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                sh <= {sh[BYTE_W-2:0], mosi};
                if (cnt == LAST) begin
                    cnt       <= '0;
                    byte_done <= 1'b1;
                    byte_q    <= {sh[BYTE_W-2:0], mosi};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign at_boundary = (cnt == '0);

endmodule

// File: rtl/spi_rp_ctrl.sv
module spi_rp_ctrl
    import spi_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_q,
    output phase_e            phase,
    output logic              rd_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata
);
    cmd_t cmd;
    assign cmd = decode_cmd(byte_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CMD;
            rd_en <= 1'b0;
            wr_en <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            rd_en <= 1'b0;
            wr_en <= 1'b0;
            if (!sel) begin
                phase <= PH_CMD;
            end else if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        if (!cmd.legal) begin
                            phase <= PH_DROP;
                        end else if (cmd.is_read) begin
                            phase <= PH_READ;
                            addr  <= cmd.addr;
                            rd_en <= 1'b1;
                        end else begin
                            phase <= PH_WRITE;
                            addr  <= cmd.addr;
                        end
                    end
                    PH_WRITE: begin
                        wr_en <= 1'b1;
                        wdata <= byte_q;
                    end
                    PH_READ: begin
                        addr  <= cmd.addr;
                        rd_en <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_rp_tx.sv
module spi_rp_tx
    import spi_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              fall,
    input  logic              at_boundary,
    input  logic              byte_done,
    input  logic              cap,
    input  logic [BYTE_W-1:0] rdata,
    output logic              miso
);
    logic [BYTE_W-1:0] load_q;
    logic [BYTE_W-1:0] sh;
    logic              cap_d;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            load_q <= '0;
            sh     <= '0;
            cap_d  <= 1'b0;
            miso   <= 1'b0;
        end else begin
            cap_d <= cap;
            if (byte_done)  load_q <= '0;
            else if (cap_d) load_q <= rdata;
            if (fall) begin
                if (at_boundary) begin
                    miso <= load_q[BYTE_W-1];
                    sh   <= {load_q[BYTE_W-2:0], 1'b0};
                end else begin
                    miso <= sh[BYTE_W-1];
                    sh   <= {sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_rp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              sel;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_q;
    logic              at_boundary;
    phase_e            phase;

    spi_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .sel(sel), .rise(sck_rise), .fall(sck_fall), .mosi_s(mosi_s)
    );

    spi_rp_rx u_rx (
        .clk(clk), .rst(rst), .sel(sel), .rise(sck_rise), .mosi(mosi_s),
        .byte_done(byte_done), .byte_q(byte_q), .at_boundary(at_boundary)
    );

    spi_rp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .byte_done(byte_done), .byte_q(byte_q),
        .phase(phase), .rd_en(reg_rd_en), .wr_en(reg_wr_en),
        .addr(reg_addr), .wdata(reg_wdata)
    );

    spi_rp_tx u_tx (
        .clk(clk), .rst(rst), .sel(sel), .fall(sck_fall), .at_boundary(at_boundary),
        .byte_done(byte_done), .cap(reg_rd_en), .rdata(reg_rdata), .miso(spi_miso)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_rp_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   sel,
    input logic   fall,
    input phase_e phase,
    input logic   spi_miso,
    input logic   reg_rd_en,
    input logic   reg_wr_en
);
    p_miso_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_miso) |-> ($past(fall) || !$past(sel)));

    p_miso_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (spi_miso == 1'b0));

    p_drop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DROP) |-> (!reg_rd_en && !reg_wr_en));

    p_wr_in_stream_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (phase == PH_WRITE));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_en && reg_wr_en));

    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en);

    p_wr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .fall(sck_fall), .phase(phase),
    .spi_miso(spi_miso), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
    import spi_rp_pkg::*;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       miso;
    logic       rd_en, wr_en;
    logic [5:0] addr;
    logic [7:0] wdata, rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_regport u_spi_regport (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .reg_rd_en(rd_en), .reg_wr_en(wr_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];
    int         wr_seen, rd_seen;
    logic [5:0] last_wr_addr;
    logic       rd_q, wr_q, both_seen, stretch_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            rdata <= '0; wr_seen <= 0; rd_seen <= 0; last_wr_addr <= '0;
            rd_q <= 1'b0; wr_q <= 1'b0; both_seen <= 1'b0; stretch_seen <= 1'b0;
        end else begin
            if (wr_en) begin
                mem[addr]    <= wdata;
                wr_seen      <= wr_seen + 1;
                last_wr_addr <= addr;
            end
            if (rd_en) begin
                rdata   <= mem[addr];
                rd_seen <= rd_seen + 1;
            end
            if (rd_en && wr_en) both_seen <= 1'b1;
            if ((rd_en && rd_q) || (wr_en && wr_q)) stretch_seen <= 1'b1;
            rd_q <= rd_en;
            wr_q <= wr_en;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        logic steady;
        steady = 1'b1;
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HP);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HP);
            if (miso !== rx[i]) steady = 1'b0;
            sck = 1'b0;
        end
        chk("R5 miso steady while sck high", 32'(steady), 32'd1);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic open_xfer();
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic close_xfer();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(3 * HP);
    endtask

    task automatic write_xfer(input logic [5:0] a, input int n);
        logic [7:0] r, d;
        int w0;
        w0 = wr_seen;
        open_xfer();
        spi_byte({1'b0, a, 1'b0}, r);
        chk("R3 miso zero in write command", 32'(r), 32'd0);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            spi_byte(d, r);
            exp_mem[a] = d;
            chk("R3 miso zero in write data", 32'(r), 32'd0);
        end
        close_xfer();
        chk("R3 one write per data byte", 32'(wr_seen - w0), 32'(n));
        chk("R3 streamed value lands", 32'(mem[a]), 32'(exp_mem[a]));
        chk("R2 write address decode", 32'(last_wr_addr), 32'(a));
    endtask

    task automatic read_xfer(input logic [5:0] a, input int n);
        logic [7:0] r;
        logic [5:0] prev, nxt;
        int r0;
        r0 = rd_seen;
        prev = a;
        open_xfer();
        spi_byte({1'b1, a, 1'b0}, r);
        chk("R4 miso zero in read command", 32'(r), 32'd0);
        for (int k = 0; k < n; k++) begin
            nxt = 6'($urandom);
            spi_byte({1'b1, nxt, 1'b0}, r);
            chk("R4 R9 data of previous address", 32'(r), 32'(exp_mem[prev]));
            prev = nxt;
        end
        close_xfer();
        chk("R4 one read per byte", 32'(rd_seen - r0), 32'(n + 1));
    endtask

    task automatic bad_xfer(input int n);
        logic [7:0] r;
        int w0, r0;
        w0 = wr_seen;
        r0 = rd_seen;
        open_xfer();
        spi_byte({8'($urandom) | 8'h01}, r);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'($urandom), r);
            chk("R6 miso zero after invalid command", 32'(r), 32'd0);
        end
        close_xfer();
        chk("R6 no strobes after invalid command", 32'((wr_seen - w0) + (rd_seen - r0)), 32'd0);
    endtask

    initial begin
        logic [7:0] r, d;
        int w0, r0;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        chk("R1 miso after reset", 32'(miso), 32'd0);
        chk("R1 strobes after reset", 32'({rd_en, wr_en}), 32'd0);

        write_xfer(6'h2A, 1);
        write_xfer(6'h3F, 4);
        read_xfer(6'h3F, 2);
        read_xfer(6'h00, 3);
        bad_xfer(3);

        // R7: partial command byte then deselect
        w0 = wr_seen; r0 = rd_seen;
        open_xfer();
        spi_bits(8'hFF, 5, r);
        close_xfer();
        chk("R7 partial byte makes no strobe", 32'((wr_seen - w0) + (rd_seen - r0)), 32'd0);
        chk("R7 miso zero after deselect", 32'(miso), 32'd0);
        write_xfer(6'h15, 2);
        read_xfer(6'h15, 1);

        // R7: full data byte, then partial one, then deselect
        w0 = wr_seen;
        open_xfer();
        spi_byte(8'h22, r);
        d = 8'hA5;
        spi_byte(d, r);
        exp_mem[6'h11] = d;
        spi_bits(8'h3C, 3, r);
        close_xfer();
        chk("R7 only full data byte written", 32'(wr_seen - w0), 32'd1);
        chk("R7 value of full byte kept", 32'(mem[6'h11]), 32'(d));

        for (int t = 0; t < 40; t++) begin
            int kind, len;
            kind = int'($urandom % 3);
            len  = 1 + int'($urandom % 4);
            case (kind)
                0: write_xfer(6'($urandom), len);
                1: read_xfer(6'($urandom), len);
                default: bad_xfer(len);
            endcase
        end

        for (int i = 0; i < 64; i++)
            if (mem[i] !== exp_mem[i]) chk("R3 register image", 32'(mem[i]), 32'(exp_mem[i]));
        chk("R8 strobes exclusive", 32'(both_seen), 32'd0);
        chk("R8 strobes single cycle", 32'(stretch_seen), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule